// File: doc/BRIEF.md
# Bridge Parity Error Status Tracker

This block holds the three parity-related sticky status flags of a two-port bus bridge. It observes completed transactions as a stream of one-cycle events. Each event gives the transaction kind (read, posted write or delayed write), the direction of travel, the bus on which the error showed up, whether the bridge was the master on that bus, and whether an error-line assertion or a local parity mismatch was seen. Two response-enable inputs, one per interface, gate the data-parity flags.

The flags are the primary data-parity flag, the secondary data-parity flag and the secondary parity-detected flag. They appear in a primary status word and in a secondary status word. Software clears them by writing ones to those words. Protocol engines, parity generation and data movement belong to other blocks.

Top module: `bpe_status_tracker`

## Requirements
- R1: A synchronous active-high reset clears all three flags, so both status words read all zeros.
- R2: The primary data-parity flag sits at bit 24 of `pri_status`. It sets only when the event has the bridge as master, `pri_resp_en` is 1, and either `evt_perr_seen` or `evt_parity_mismatch` is 1.
- R3: The primary data-parity flag sets only for upstream events (`evt_upstream`=1) whose error was seen on the primary bus (`evt_on_secondary`=0). This covers reads, posted writes and delayed writes. It never sets for downstream events or for secondary-bus errors.
- R4: The secondary data-parity flag sits at bit 8 of `sec_status`. It sets only when the bridge is master, `sec_resp_en` is 1, and either error indication is 1.
- R5: The secondary data-parity flag sets only for downstream events (`evt_upstream`=0) seen on the secondary bus (`evt_on_secondary`=1). This covers reads, posted writes and delayed writes.
- R6: The secondary parity-detected flag sits at bit 15 of `sec_status`. It sets for upstream posted or delayed writes seen on the secondary bus with either error indication at 1. Neither response enable nor mastership affects it. It never sets for reads, downstream events or primary-bus errors.
- R7: `evt_kind` encodes 0 as read, 1 as posted write and 2 as delayed write. Value 3 is reserved and sets no flag.
- R8: When `evt_valid` is 0, the event inputs have no effect on any flag.
- R9: A write with a 1 in a flag's bit position clears that flag. A 0 in that position leaves the flag unchanged. Other status bits always read 0.
- R10: When a set condition and a clearing write reach the same flag in the same cycle, the flag ends at 1.
- R11: A flag change shows in the status word in the clock cycle after the event or write that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | One-cycle strobe qualifying the event inputs |
| evt_kind | input | 2 | 0 read, 1 posted write, 2 delayed write, 3 reserved |
| evt_upstream | input | 1 | 1 upstream, 0 downstream |
| evt_on_secondary | input | 1 | 1 error seen on secondary bus, 0 on primary |
| evt_bridge_master | input | 1 | Bridge was master on the bus where the error was seen |
| evt_perr_seen | input | 1 | Error line sampled asserted |
| evt_parity_mismatch | input | 1 | Locally computed parity mismatch |
| pri_resp_en | input | 1 | Primary parity error response enable |
| sec_resp_en | input | 1 | Secondary parity error response enable |
| cfg_pri_wr | input | 1 | Write strobe for the primary status word |
| cfg_pri_wdata | input | 32 | Write data for the primary status word (ones clear) |
| cfg_sec_wr | input | 1 | Write strobe for the secondary status word |
| cfg_sec_wdata | input | 16 | Write data for the secondary status word (ones clear) |
| pri_status | output | 32 | Primary status word |
| sec_status | output | 16 | Secondary status word |

## Verification
The hardest case to reach is a flag set that lands in the same cycle as a write-one-to-clear of that same flag. Provoking it takes an event that already qualifies, timed to coincide with a configuration write. The bench first raises the flag, then drives a qualifying event and a clearing write on the same clock edge, and checks that the flag survives. As a contrast, it clears the neighbouring flags in that same cycle. Every qualifying mix of kind, direction, bus, mastership, error source and enables is also swept from a cleared state, and each flag is compared with a rule-derived expectation.

// File: rtl/bpe_pkg.sv
package bpe_pkg;
  typedef enum logic [1:0] {
    TK_READ    = 2'd0,
    TK_POSTED  = 2'd1,
    TK_DELAYED = 2'd2,
    TK_RSVD    = 2'd3
  } txn_kind_e;

  localparam int FLAG_PRI_DPD = 0;
  localparam int FLAG_SEC_DPD = 1;
  localparam int FLAG_SEC_DPE = 2;
  localparam int NUM_FLAGS    = 3;
endpackage

// File: rtl/bpe_set_decode.sv
module bpe_set_decode
  import bpe_pkg::*;
#(
  parameter int NF = NUM_FLAGS
) (
  input  logic          valid,
  input  logic [1:0]    kind,
  input  logic          upstream,
  input  logic          on_secondary,
  input  logic          bridge_master,
  input  logic          perr_seen,
  input  logic          parity_mismatch,
  input  logic          pri_resp_en,
  input  logic          sec_resp_en,
  output logic [NF-1:0] set_req
);
  logic err_any, is_data_kind, is_write_kind;

  always_comb begin
    err_any       = perr_seen | parity_mismatch;
    is_data_kind  = (kind == TK_READ) || (kind == TK_POSTED) || (kind == TK_DELAYED);
    is_write_kind = (kind == TK_POSTED) || (kind == TK_DELAYED);
    set_req       = '0;
    // R2 R3: upstream, primary bus, master, primary response enabled
    set_req[FLAG_PRI_DPD] = valid && err_any && is_data_kind && upstream &&
                            !on_secondary && bridge_master && pri_resp_en;
    // R4 R5: downstream, secondary bus, master, secondary response enabled
    set_req[FLAG_SEC_DPD] = valid && err_any && is_data_kind && !upstream &&
                            on_secondary && bridge_master && sec_resp_en;
    // R6: upstream writes seen on the secondary bus, enables ignored
    set_req[FLAG_SEC_DPE] = valid && err_any && is_write_kind && upstream &&
                            on_secondary;
  end
endmodule

// File: rtl/bpe_sticky_flag.sv
module bpe_sticky_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

  a_r9_hold_without_clear: assert property (@(posedge clk) disable iff (rst)
    (q && !clr) |=> q);
  a_r9_clear_takes_effect: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> !q);
  a_r10_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
    set |=> q);
endmodule

// File: rtl/bpe_status_tracker.sv
module bpe_status_tracker
  import bpe_pkg::*;
#(
  parameter int PRI_W       = 32,
  parameter int SEC_W       = 16,
  parameter int PRI_DPD_BIT = 24,
  parameter int SEC_DPD_BIT = 8,
  parameter int SEC_DPE_BIT = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_valid,
  input  logic [1:0]       evt_kind,
  input  logic             evt_upstream,
  input  logic             evt_on_secondary,
  input  logic             evt_bridge_master,
  input  logic             evt_perr_seen,
  input  logic             evt_parity_mismatch,
  input  logic             pri_resp_en,
  input  logic             sec_resp_en,
  input  logic             cfg_pri_wr,
  input  logic [PRI_W-1:0] cfg_pri_wdata,
  input  logic             cfg_sec_wr,
  input  logic [SEC_W-1:0] cfg_sec_wdata,
  output logic [PRI_W-1:0] pri_status,
  output logic [SEC_W-1:0] sec_status
);
  localparam int NF = NUM_FLAGS;

  logic [NF-1:0] set_req, clr_req, flag_q;
  logic unused_wdata;

  assign unused_wdata = ^{cfg_pri_wdata, cfg_sec_wdata};

  bpe_set_decode #(.NF(NF)) u_decode (
    .valid           (evt_valid),
    .kind            (evt_kind),
    .upstream        (evt_upstream),
    .on_secondary    (evt_on_secondary),
    .bridge_master   (evt_bridge_master),
    .perr_seen       (evt_perr_seen),
    .parity_mismatch (evt_parity_mismatch),
    .pri_resp_en     (pri_resp_en),
    .sec_resp_en     (sec_resp_en),
    .set_req         (set_req)
  );

  always_comb begin
    clr_req               = '0;
    clr_req[FLAG_PRI_DPD] = cfg_pri_wr && cfg_pri_wdata[PRI_DPD_BIT];
    clr_req[FLAG_SEC_DPD] = cfg_sec_wr && cfg_sec_wdata[SEC_DPD_BIT];
    clr_req[FLAG_SEC_DPE] = cfg_sec_wr && cfg_sec_wdata[SEC_DPE_BIT];
  end

  for (genvar g = 0; g < NF; g++) begin : g_flag
    bpe_sticky_flag u_flag (
      .clk (clk),
      .rst (rst),
      .set (set_req[g]),
      .clr (clr_req[g]),
      .q   (flag_q[g])
    );
  end

  always_comb begin
    pri_status              = '0;
    pri_status[PRI_DPD_BIT] = flag_q[FLAG_PRI_DPD];
    sec_status              = '0;
    sec_status[SEC_DPD_BIT] = flag_q[FLAG_SEC_DPD];
    sec_status[SEC_DPE_BIT] = flag_q[FLAG_SEC_DPE];
  end

  a_r3_pri_rise_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(pri_status[PRI_DPD_BIT]) |->
      $past(evt_valid && evt_upstream && !evt_on_secondary &&
            evt_bridge_master && pri_resp_en));
  a_r5_sec_rise_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(sec_status[SEC_DPD_BIT]) |->
      $past(evt_valid && !evt_upstream && evt_on_secondary &&
            evt_bridge_master && sec_resp_en));
  a_r6_dpe_rise_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(sec_status[SEC_DPE_BIT]) |->
      $past(evt_valid && evt_upstream && evt_on_secondary &&
            evt_kind != TK_READ && evt_kind != TK_RSVD));
  a_r8_idle_no_rise: assert property (@(posedge clk) disable iff (rst)
    !evt_valid |=> !$rose(pri_status[PRI_DPD_BIT]) && !$rose(sec_status[SEC_DPD_BIT])
                   && !$rose(sec_status[SEC_DPE_BIT]));
endmodule

// File: tb/tb_bpe_status_tracker.sv
`timescale 1ns/1ps
module tb_bpe_status_tracker;
  logic clk = 1'b0;
  logic rst;
  logic evt_valid, evt_upstream, evt_on_secondary, evt_bridge_master;
  logic evt_perr_seen, evt_parity_mismatch, pri_resp_en, sec_resp_en;
  logic [1:0] evt_kind;
  logic cfg_pri_wr, cfg_sec_wr;
  logic [31:0] cfg_pri_wdata, pri_status;
  logic [15:0] cfg_sec_wdata, sec_status;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  bpe_status_tracker dut (
    .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_kind(evt_kind),
    .evt_upstream(evt_upstream), .evt_on_secondary(evt_on_secondary),
    .evt_bridge_master(evt_bridge_master), .evt_perr_seen(evt_perr_seen),
    .evt_parity_mismatch(evt_parity_mismatch), .pri_resp_en(pri_resp_en),
    .sec_resp_en(sec_resp_en), .cfg_pri_wr(cfg_pri_wr), .cfg_pri_wdata(cfg_pri_wdata),
    .cfg_sec_wr(cfg_sec_wr), .cfg_sec_wdata(cfg_sec_wdata),
    .pri_status(pri_status), .sec_status(sec_status)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    evt_valid = 0; evt_kind = 0; evt_upstream = 0; evt_on_secondary = 0;
    evt_bridge_master = 0; evt_perr_seen = 0; evt_parity_mismatch = 0;
    cfg_pri_wr = 0; cfg_sec_wr = 0; cfg_pri_wdata = 0; cfg_sec_wdata = 0;
  endtask

  task automatic drive_evt(input logic [1:0] k, input logic up, input logic sec,
                           input logic m, input logic pe, input logic mm);
    evt_valid = 1; evt_kind = k; evt_upstream = up; evt_on_secondary = sec;
    evt_bridge_master = m; evt_perr_seen = pe; evt_parity_mismatch = mm;
  endtask

  task automatic clear_all();
    @(negedge clk);
    idle_inputs();
    cfg_pri_wr = 1; cfg_pri_wdata = '1; cfg_sec_wr = 1; cfg_sec_wdata = '1;
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    pri_resp_en = 0; sec_resp_en = 0;
    rst = 1;
    repeat (3) @(negedge clk);
    check("R1 pri reset", pri_status, 32'h0);
    check("R1 sec reset", {16'h0, sec_status}, 32'h0);
    rst = 0;

    // Exhaustive sweep: R2..R8, R11
    for (int v = 0; v < 1024; v++) begin
      logic vld, up, sec, m, pe, mm, pre, sre;
      logic [1:0] k;
      logic err, data_k, wr_k, e_pri, e_sdp, e_dpe;
      {vld, k, up, sec, m, pe, mm, pre, sre} = 10'(v);
      err    = pe | mm;
      data_k = (k != 2'd3);
      wr_k   = (k == 2'd1) || (k == 2'd2);
      e_pri  = vld && err && data_k && up && !sec && m && pre;
      e_sdp  = vld && err && data_k && !up && sec && m && sre;
      e_dpe  = vld && err && wr_k && up && sec;
      @(negedge clk);
      pri_resp_en = pre; sec_resp_en = sre;
      drive_evt(k, up, sec, m, pe, mm);
      evt_valid = vld;
      @(negedge clk);
      idle_inputs();
      check("R2 R3 R7 R8 R11 pri flag", {31'h0, pri_status[24]}, {31'h0, e_pri});
      check("R4 R5 R7 R8 R11 sec dpd flag", {31'h0, sec_status[8]}, {31'h0, e_sdp});
      check("R6 R7 R8 R11 sec dpe flag", {31'h0, sec_status[15]}, {31'h0, e_dpe});
      check("R9 other bits zero", {pri_status & ~32'h0100_0000},  32'h0);
      clear_all();
    end

    // Raise all three flags
    pri_resp_en = 1; sec_resp_en = 1;
    @(negedge clk); drive_evt(2'd0, 1, 0, 1, 1, 0);
    @(negedge clk); drive_evt(2'd1, 0, 1, 1, 0, 1);
    @(negedge clk); drive_evt(2'd2, 1, 1, 0, 1, 0);
    @(negedge clk); idle_inputs();
    check("R2 pri set", pri_status, 32'h0100_0000);
    check("R4 R6 sec set", {16'h0, sec_status}, 32'h0000_8100);

    // R9: writing zeros in flag positions keeps flags
    cfg_pri_wr = 1; cfg_pri_wdata = ~32'h0100_0000;
    cfg_sec_wr = 1; cfg_sec_wdata = ~16'h8100;
    @(negedge clk); idle_inputs();
    check("R9 zero write keeps pri", pri_status, 32'h0100_0000);
    check("R9 zero write keeps sec", {16'h0, sec_status}, 32'h0000_8100);

    // R9: non-qualifying event leaves sticky flags
    drive_evt(2'd0, 0, 0, 1, 1, 1);
    @(negedge clk); idle_inputs();
    check("R9 sticky pri", pri_status, 32'h0100_0000);

    // R9: clear only dpd in secondary word
    cfg_sec_wr = 1; cfg_sec_wdata = 16'h0100;
    @(negedge clk); idle_inputs();
    check("R9 selective clear sec", {16'h0, sec_status}, 32'h0000_8000);
    check("R9 pri untouched", pri_status, 32'h0100_0000);

    // R10: set and clear same cycle on pri flag; sec dpe cleared for contrast
    drive_evt(2'd1, 1, 0, 1, 0, 1);
    cfg_pri_wr = 1; cfg_pri_wdata = 32'h0100_0000;
    cfg_sec_wr = 1; cfg_sec_wdata = 16'h8000;
    @(negedge clk); idle_inputs();
    check("R10 set wins pri", pri_status, 32'h0100_0000);
    check("R9 contrast dpe cleared", {16'h0, sec_status}, 32'h0);

    // R10 on secondary dpe: set with clear in same cycle
    drive_evt(2'd2, 1, 1, 0, 0, 1);
    cfg_sec_wr = 1; cfg_sec_wdata = 16'hFFFF;
    @(negedge clk); idle_inputs();
    check("R10 set wins dpe", {16'h0, sec_status}, 32'h0000_8000);

    // R9: clear pri
    cfg_pri_wr = 1; cfg_pri_wdata = 32'h0100_0000;
    @(negedge clk); idle_inputs();
    check("R9 pri cleared", pri_status, 32'h0);

    // R1: reset clears a set flag
    rst = 1;
    @(negedge clk); rst = 0;
    check("R1 reset clears sec", {16'h0, sec_status}, 32'h0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule